// File: doc/BRIEF.md
# Platform Status Lamp Driver

This block drives two indicator lamps, a green power lamp and an orange adapter lamp, from a few platform status levels. The inputs are decoded with a fixed priority. A running processor shows a steady green lamp. A suspended platform shows a blinking green lamp. A powered-off platform with the adapter attached shows the orange lamp. Any other state leaves both lamps dark.

The blink is timed from a one-cycle millisecond tick. Each tick advances a free-running time counter. A stored timestamp marks the last blink toggle. The green level flips when the counter has moved `BLINK_TICKS` ticks past that timestamp. It also flips at once when the counter wraps to a value below the timestamp. Lamp outputs follow the inputs combinationally. Only the blink level and the time state are registered.

Top module: `status_lamp_drv`

## Requirements
- R1: While `plat_run` is 1, `lamp_green` is 1 and `lamp_orange` is 0, whatever the other inputs are.
- R2: While `plat_run` is 0 and `sleep_s4` is 1 (suspend), `lamp_orange` is 0 and `lamp_green` shows the blink level. The level toggles at the clock edge where the time counter is at least the stamp plus `BLINK_TICKS`, and the stamp then takes the counter value.
- R3: While `plat_run` is 0, `sleep_s4` is 0 and `adapter_n` is 0 (adapter present, active-low), `lamp_orange` is 1 and `lamp_green` is 0.
- R4: While `plat_run`, `sleep_s4` and `adapter_n` are 0, 0 and 1, both lamps are 0.
- R5: In suspend, a time counter value below the stamp (the counter has wrapped) toggles the blink level at the next edge and reloads the stamp from the counter.
- R6: Outside suspend, the blink level holds and the stamp follows the counter. On re-entry the lamp resumes at the held level, and the full period is timed from the entry cycle.
- R7: A synchronous active-low reset clears the time counter, the stamp and the blink level to 0, so the green lamp is off in suspend straight after reset.
- R8: The time counter advances by one, modulo 2^`TIME_W`, at each clock edge where `ms_tick` is 1. It is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| plat_run | input | 1 | 1 when platform reset is released (processor running) |
| sleep_s4 | input | 1 | 1 when the deep-sleep level indicates suspend |
| adapter_n | input | 1 | 0 when the power adapter is present |
| ms_tick | input | 1 | One-cycle millisecond tick pulse |
| lamp_green | output | 1 | Green power lamp drive |
| lamp_orange | output | 1 | Orange adapter lamp drive |

## Verification
The lamp outputs change in the same cycle as a mode input, because the priority decode is combinational. A blink toggle becomes visible one cycle after the edge at which the counter condition held. A tick raises the counter at the edge that samples it. The bench drives inputs and compares at the falling edge. A reference model, updated at each rising edge from the values sampled there, predicts the blink level and the stamp, so every cycle's comparison falls after all of these delays have settled.

// File: rtl/lamp_pkg.sv
// Shared types for the status lamp driver.
package lamp_pkg;
    // Decoded lamp mode, listed from highest to lowest priority.
    typedef enum logic [1:0] {
        LM_RUN     = 2'd0,
        LM_SUSPEND = 2'd1,
        LM_ADAPTER = 2'd2,
        LM_DARK    = 2'd3
    } lamp_mode_e;
endpackage

// File: rtl/lamp_mode_sel.sv
// Priority decode of the platform status levels into one lamp mode.
// Assumes the inputs are already synchronous to clk.
module lamp_mode_sel
    import lamp_pkg::*;
(
    input  logic       plat_run,
    input  logic       sleep_s4,
    input  logic       adapter_n,
    output lamp_mode_e mode
);
    // Strict priority: run, then suspend, then adapter, then dark.
    always_comb begin
        if (plat_run)        mode = LM_RUN;
        else if (sleep_s4)   mode = LM_SUSPEND;
        else if (!adapter_n) mode = LM_ADAPTER;
        else                 mode = LM_DARK;
    end
endmodule

// File: rtl/lamp_tick_clock.sv
// Free-running time counter advanced by a one-cycle tick pulse.
// Assumes the tick is never high for more than one cycle per period.
module lamp_tick_clock #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [TIME_W-1:0] now
);
    // Count ticks; wraps naturally at 2^TIME_W.
    always_ff @(posedge clk) begin
        if (!rst_n)    now <= '0;
        else if (tick) now <= now + 1'b1;
    end

    // R8
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> now == $past(now) + TIME_W'(1));
    // R8
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(now));
endmodule

// File: rtl/lamp_blink_timer.sv
// Blink level generator with wrap-safe elapsed-time test.
// Toggles the level when the counter is BLINK_TICKS past the stamp or
// has wrapped below it; outside blink mode the stamp tracks the counter.
module lamp_blink_timer #(
    parameter int TIME_W      = 32,
    parameter int BLINK_TICKS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blink_en,
    input  logic [TIME_W-1:0] now,
    output logic              level
);
    localparam int EXT_W = TIME_W + 1;

    logic [TIME_W-1:0] stamp;
    logic [EXT_W-1:0]  due;
    logic              wrapped;
    logic              reached;
    logic              fire;

    // Elapsed-time tests done one bit wider so the sum cannot overflow.
    always_comb begin
        due     = {1'b0, stamp} + EXT_W'(BLINK_TICKS);
        wrapped = now < stamp;
        reached = {1'b0, now} >= due;
        fire    = blink_en && (wrapped || reached);
    end

    // Update stamp and blink level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp <= '0;
            level <= 1'b0;
        end else begin
            if (!blink_en || fire) stamp <= now;
            if (fire)              level <= ~level;
        end
    end

    // R6
    hold_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en |=> $stable(level));
    // R5
    wrap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && now < stamp) |=> level != $past(level));
    // R2
    early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && now >= stamp && ({1'b0, now} < {1'b0, stamp} + EXT_W'(BLINK_TICKS)))
        |=> $stable(level));
endmodule

// File: rtl/status_lamp_drv.sv
// Status lamp driver top: priority mode decode, tick-timed blink and
// lamp output mapping. Inputs are assumed synchronous to clk.
module status_lamp_drv
    import lamp_pkg::*;
#(
    parameter int TIME_W      = 32,
    parameter int BLINK_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic plat_run,
    input  logic sleep_s4,
    input  logic adapter_n,
    input  logic ms_tick,
    output logic lamp_green,
    output logic lamp_orange
);
    lamp_mode_e        mode;
    logic [TIME_W-1:0] now;
    logic              blink_level;
    logic              blink_en;

    lamp_mode_sel u_sel (
        .plat_run  (plat_run),
        .sleep_s4  (sleep_s4),
        .adapter_n (adapter_n),
        .mode      (mode)
    );

    lamp_tick_clock #(.TIME_W(TIME_W)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ms_tick),
        .now   (now)
    );

    // Blink timing is active only in suspend mode.
    always_comb blink_en = (mode == LM_SUSPEND);

    lamp_blink_timer #(.TIME_W(TIME_W), .BLINK_TICKS(BLINK_TICKS)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .blink_en (blink_en),
        .now      (now),
        .level    (blink_level)
    );

    // Map the mode to the two lamp drives.
    always_comb begin
        unique case (mode)
            LM_RUN:     begin lamp_green = 1'b1;        lamp_orange = 1'b0; end
            LM_SUSPEND: begin lamp_green = blink_level; lamp_orange = 1'b0; end
            LM_ADAPTER: begin lamp_green = 1'b0;        lamp_orange = 1'b1; end
            default:    begin lamp_green = 1'b0;        lamp_orange = 1'b0; end
        endcase
    end

    // R1
    run_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plat_run |-> (lamp_green && !lamp_orange));
    // R3
    adapter_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!plat_run && !sleep_s4 && !adapter_n) |-> (lamp_orange && !lamp_green));
    // R4
    dark_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!plat_run && !sleep_s4 && adapter_n) |-> (!lamp_orange && !lamp_green));
    // R2
    suspend_orange_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!plat_run && sleep_s4) |-> !lamp_orange);
endmodule

// File: tb/sim_status_lamp_drv.sv
module sim_status_lamp_drv;
    localparam int TW = 8;
    localparam int PER = 40;
    localparam int MODV = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic plat_run = 1'b0;
    logic sleep_s4 = 1'b1;
    logic adapter_n = 1'b1;
    logic ms_tick = 1'b0;
    logic lamp_green;
    logic lamp_orange;

    int total = 0;
    int bad = 0;
    int tick_phase = 0;
    int tick_every = 3;
    string tag = "R7";

    int m_cnt = 0;
    int m_last = 0;
    int m_lvl = 0;
    int toggles = 0;

    always #5 clk = ~clk;

    status_lamp_drv #(.TIME_W(TW), .BLINK_TICKS(PER)) u0 (
        .clk(clk), .rst_n(rst_n), .plat_run(plat_run), .sleep_s4(sleep_s4),
        .adapter_n(adapter_n), .ms_tick(ms_tick),
        .lamp_green(lamp_green), .lamp_orange(lamp_orange)
    );

    // Behavioural reference model, updated from the values at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_last = 0; m_lvl = 0;
        end else begin
            if (!plat_run && sleep_s4) begin
                if (m_cnt < m_last || m_cnt >= m_last + PER) begin
                    m_lvl = 1 - m_lvl;
                    m_last = m_cnt;
                    toggles++;
                end
            end else begin
                m_last = m_cnt;
            end
            if (ms_tick) m_cnt = (m_cnt + 1) % MODV;
        end
    end

    task automatic compare();
        int eg;
        int eo;
        if (plat_run) begin eg = 1; eo = 0; end
        else if (sleep_s4) begin eg = m_lvl; eo = 0; end
        else if (!adapter_n) begin eg = 0; eo = 1; end
        else begin eg = 0; eo = 0; end
        total++;
        if (int'(lamp_green) != eg || int'(lamp_orange) != eo) begin
            bad++;
            $display("FAIL %s: green/orange actual=%0d/%0d expected=%0d/%0d at %0t",
                     tag, lamp_green, lamp_orange, eg, eo, $time);
        end
    endtask

    // Advance n cycles: check at the falling edge, then drive the next tick.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            ms_tick = (tick_every > 0) && (tick_phase % tick_every == 0);
            tick_phase++;
        end
    endtask

    task automatic set_in(input logic r, input logic s, input logic a);
        plat_run = r; sleep_s4 = s; adapter_n = a;
    endtask

    initial begin
        int t0;
        // R7: reset state, suspend inputs present, green must be off.
        tag = "R7";
        step(4);
        rst_n = 1'b1;
        step(20);

        // R1: run mode overrides sleep and adapter levels.
        tag = "R1";
        set_in(1, 1, 0); step(10);
        set_in(1, 0, 1); step(10);
        set_in(1, 1, 1); step(10);

        // R2: suspend blinking over several periods.
        tag = "R2";
        set_in(0, 1, 1);
        t0 = toggles;
        step(500);
        total++;
        if (toggles - t0 < 3) begin
            bad++;
            $display("FAIL R2: toggles actual=%0d expected>=3", toggles - t0);
        end
        // R8/R2: ticks stopped, the level must not move.
        tag = "R8";
        tick_every = 0;
        step(300);
        tick_every = 3;

        // R3 and R4: off states.
        tag = "R3";
        set_in(0, 0, 0); step(30);
        tag = "R4";
        set_in(0, 0, 1); step(30);

        // R6: leave suspend midway, hold, re-enter.
        tag = "R6";
        set_in(0, 1, 0); step(70);
        set_in(0, 0, 0); step(200);
        set_in(0, 1, 0); step(200);
        set_in(1, 1, 0); step(50);
        set_in(0, 1, 1); step(150);

        // R5: enter suspend with the counter near its top, so it wraps.
        tag = "R5";
        set_in(0, 0, 1);
        while (m_cnt != 230) step(1);
        set_in(0, 1, 1);
        t0 = toggles;
        while (m_cnt != 1) step(1);
        step(2);
        total++;
        if (toggles - t0 != 1) begin
            bad++;
            $display("FAIL R5: toggles at wrap actual=%0d expected=1", toggles - t0);
        end
        step(200);

        // R7: reset again in suspend clears the level.
        tag = "R7";
        rst_n = 1'b0; step(3);
        rst_n = 1'b1; step(20);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog: run did not end actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule